// File: doc/BRIEF.md
# ASCII Scan-Port Bit-Bang Command Engine

This block sits between a byte-wide serial link from a host and the four test-port lines of a target device. The host types short ASCII commands. The engine reads a pin level, forces one of its own output pins, or runs a scan sequence that moves TMS and TDI and emits TCK pulses. Every TDO level that the pulses produce is recorded.

Each character takes effect in the cycle it is accepted. The textual reply waits until the newline that closes a valid command, and then goes out on the outgoing byte channel. While the reply is in flight, a transmit-enable output is raised, so that the serial driver can be shared with other responders. A malformed command, an unknown pin and a `#` remark are all dropped silently, up to and including their newline. Carriage returns are skipped everywhere. The receive channel is held off while a TCK pulse or a reply is in progress.

Top module: `scan_cmd_engine`

## Requirements
- R1: After reset, tck_o=0, tms_o=1, tdi_o=1, tgt_rst_n_o=1, test_out_o=0, tx_valid=0 and tx_enable=0.
- R2: The read command `r` plus a pin letter plus LF replies "m> " plus the letter, ':', then '0' or '1' for the level sampled when the letter arrived, plus LF. The pin letters are: a=test_out_o, q=test_in_i, r=tgt_rst_n_o, c=tck_o, m=tms_o, i=tdi_o, o=tdo_i.
- R3: The write command `w`, a writable letter (m, c, i, r, a), then '0' or '1' drives that pin when the level byte arrives. After LF it replies "m> " plus the letter, ':', the old level, "->", the new level, plus LF.
- R4: A bad pin letter, a non-writable letter in a write (q, o), or any unexpected character makes the engine drop input up to LF. No reply is sent and no pin changes.
- R5: The scan command `j` accepts any number of items. `m` with a level sets tms_o, and `i` with a level sets tdi_o, each when its level byte arrives.
- R6: In a scan command, `^` raises tck_o for HALF_CYC clocks and then holds it low for HALF_CYC clocks before the next byte is accepted. tdo_i is sampled on the clock where tck_o falls.
- R7: At LF, a scan command replies "m> ", then one '0'/'1' per recorded TDO sample in pulse order, then " ok" and LF. A command with no pulses gives "m>  ok".
- R8: At most CAP_DEPTH samples are recorded per scan command. Later pulses still toggle tck_o but add no characters.
- R9: `#` at the start of a line drops everything through the next LF, and no reply is sent.
- R10: A carriage return (0x0D) is ignored in every parser state.
- R11: tx_enable is high exactly while reply bytes are pending. While tx_ready is low, tx_valid and tx_data hold steady.
- R12: rx_ready is low while a TCK pulse or a reply is in progress.
- R13: Pin effects happen before the terminating LF, and no reply byte appears before that LF is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Incoming command byte |
| rx_valid | input | 1 | Incoming byte present |
| rx_ready | output | 1 | Engine can take a byte |
| tx_data | output | 8 | Reply byte |
| tx_valid | output | 1 | Reply byte present |
| tx_ready | input | 1 | Downstream takes the reply byte |
| tx_enable | output | 1 | Serial driver enable, high while replying |
| tck_o | output | 1 | Test clock to target |
| tms_o | output | 1 | Test mode select to target |
| tdi_o | output | 1 | Test data to target |
| tgt_rst_n_o | output | 1 | Target reset, low active |
| test_out_o | output | 1 | General test output |
| tdo_i | input | 1 | Test data from target |
| test_in_i | input | 1 | General test input |

## Verification
A pin write or a TMS/TDI item is visible on its output one clock after the level byte is accepted. The bench looks at it on the following falling edge, before any newline is sent. A `^` raises tck_o on the edge that accepts it. The bench then counts falling edges to measure HALF_CYC clocks high and HALF_CYC clocks low before rx_ready returns. The first reply byte is valid one clock after the LF is accepted. The collector records a byte only at falling edges where both tx_valid and tx_ready are high, and each reply is compared only after a quiet window longer than the longest possible reply.

// File: rtl/scan_cmd_pkg.sv
package scan_cmd_pkg;

    localparam logic [7:0] CH_LF = 8'h0A;
    localparam logic [7:0] CH_CR = 8'h0D;

    typedef enum logic [3:0] {
        P_IDLE, P_RD_PIN, P_RD_END, P_WR_PIN, P_WR_LVL, P_WR_END,
        P_JTAG, P_J_TMS, P_J_TDI, P_SKIP
    } pstate_t;

    typedef enum logic [1:0] {RK_READ, RK_WRITE, RK_JTAG} rkind_t;

    typedef struct packed {
        rkind_t     kind;
        logic [7:0] pin;
        logic       old_lvl;
        logic       new_lvl;
    } reply_info_t;

    typedef struct packed {
        logic tck;
        logic tms;
        logic tdi;
        logic rst_n;
        logic tout;
    } pin_state_t;

    localparam pin_state_t PINS_RESET = '{tck: 1'b0, tms: 1'b1, tdi: 1'b1,
                                          rst_n: 1'b1, tout: 1'b0};

    function automatic logic is_level(logic [7:0] c);
        return (c == "0") || (c == "1");
    endfunction

    function automatic logic is_readable(logic [7:0] c);
        return (c == "a") || (c == "q") || (c == "r") || (c == "c") ||
               (c == "m") || (c == "i") || (c == "o");
    endfunction

    function automatic logic is_writable(logic [7:0] c);
        return (c == "a") || (c == "r") || (c == "c") || (c == "m") || (c == "i");
    endfunction

    function automatic pstate_t bad_next(logic [7:0] c);
        return (c == CH_LF) ? P_IDLE : P_SKIP;
    endfunction

    function automatic logic pin_level(logic [7:0] c, pin_state_t p,
                                       logic tdo, logic tin);
        logic v;
        case (c)
            "a":     v = p.tout;
            "q":     v = tin;
            "r":     v = p.rst_n;
            "c":     v = p.tck;
            "m":     v = p.tms;
            "i":     v = p.tdi;
            "o":     v = tdo;
            default: v = 1'b0;
        endcase
        return v;
    endfunction

    function automatic logic [7:0] lvl_char(logic b);
        return {7'b0011000, b};
    endfunction

    function automatic int reply_len(rkind_t k, int cnt);
        int n;
        case (k)
            RK_READ:  n = 7;
            RK_WRITE: n = 10;
            default:  n = cnt + 7;
        endcase
        return n;
    endfunction

    function automatic logic [7:0] reply_char(reply_info_t inf, logic [63:0] bits,
                                              int cnt, int idx);
        logic [7:0] c;
        c = CH_LF;
        if (idx == 0)      c = "m";
        else if (idx == 1) c = ">";
        else if (idx == 2) c = " ";
        else begin
            case (inf.kind)
                RK_READ: begin
                    case (idx)
                        3:       c = inf.pin;
                        4:       c = ":";
                        5:       c = lvl_char(inf.new_lvl);
                        default: c = CH_LF;
                    endcase
                end
                RK_WRITE: begin
                    case (idx)
                        3:       c = inf.pin;
                        4:       c = ":";
                        5:       c = lvl_char(inf.old_lvl);
                        6:       c = "-";
                        7:       c = ">";
                        8:       c = lvl_char(inf.new_lvl);
                        default: c = CH_LF;
                    endcase
                end
                default: begin
                    if (idx - 3 < cnt) c = lvl_char(bits[6'(idx - 3)]);
                    else begin
                        case (idx - 3 - cnt)
                            0:       c = " ";
                            1:       c = "o";
                            2:       c = "k";
                            default: c = CH_LF;
                        endcase
                    end
                end
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/scan_cmd_pulse.sv
module scan_cmd_pulse
    import scan_cmd_pkg::*;
#(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic fall_stb
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(HALF_CYC - 1);

    logic          high_ph;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            high_ph <= 1'b0;
            cnt     <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            high_ph <= 1'b1;
            cnt     <= RELOAD;
        end else if (busy) begin
            if (cnt == '0) begin
                if (high_ph) begin
                    high_ph <= 1'b0;
                    cnt     <= RELOAD;
                end else begin
                    busy <= 1'b0;
                end
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign fall_stb = busy && high_ph && (cnt == '0);

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy); // R12

endmodule

// File: rtl/scan_cmd_reply.sv
module scan_cmd_reply
    import scan_cmd_pkg::*;
#(
    parameter int CAP_DEPTH = 32,
    parameter int CNT_W     = 6,
    parameter int IDX_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  reply_info_t          info,
    input  logic [CAP_DEPTH-1:0] bits,
    input  logic [CNT_W-1:0]     cnt,
    input  logic                 tx_ready,
    output logic                 tx_valid,
    output logic [7:0]           tx_data,
    output logic                 busy
);
    logic [IDX_W-1:0] idx;
    logic             last;

    assign last     = (int'(idx) == reply_len(info.kind, int'(cnt)) - 1);
    assign tx_valid = busy;
    assign tx_data  = reply_char(info, 64'(bits), int'(cnt), int'(idx));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            idx  <= '0;
        end else if (busy && tx_ready) begin
            if (last) busy <= 1'b0;
            else      idx  <= idx + 1'b1;
        end
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R11

endmodule

// File: rtl/scan_cmd_parser.sv
module scan_cmd_parser
    import scan_cmd_pkg::*;
#(
    parameter int CAP_DEPTH = 32,
    parameter int CNT_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_fire,
    input  logic [7:0]           rx_byte,
    input  logic                 fall_stb,
    input  logic                 tdo_i,
    input  logic                 test_in_i,
    output logic                 pulse_start,
    output logic                 reply_start,
    output reply_info_t          info,
    output logic [CAP_DEPTH-1:0] cap_bits,
    output logic [CNT_W-1:0]     cap_cnt,
    output pin_state_t           pins
);
    localparam int IX_W = (CAP_DEPTH > 1) ? $clog2(CAP_DEPTH) : 1;
    localparam logic [CNT_W-1:0] CAP_LIM = CNT_W'(CAP_DEPTH);

    pstate_t st;
    logic    take;

    assign take        = rx_fire && (rx_byte != CH_CR);
    assign pulse_start = take && (st == P_JTAG) && (rx_byte == "^");
    assign reply_start = take && (rx_byte == CH_LF) &&
                         ((st == P_RD_END) || (st == P_WR_END) || (st == P_JTAG));

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= P_IDLE;
            pins     <= PINS_RESET;
            info     <= '{kind: RK_READ, pin: 8'h00, old_lvl: 1'b0, new_lvl: 1'b0};
            cap_bits <= '0;
            cap_cnt  <= '0;
        end else begin
            if (fall_stb) begin
                pins.tck <= 1'b0;
                if (cap_cnt < CAP_LIM) begin
                    cap_bits[cap_cnt[IX_W-1:0]] <= tdo_i;
                    cap_cnt <= cap_cnt + 1'b1;
                end
            end
            if (take) begin
                case (st)
                    P_IDLE: begin
                        case (rx_byte)
                            "r":     st <= P_RD_PIN;
                            "w":     st <= P_WR_PIN;
                            "j": begin
                                st       <= P_JTAG;
                                cap_cnt  <= '0;
                                cap_bits <= '0;
                            end
                            "#":     st <= P_SKIP;
                            CH_LF:   st <= P_IDLE;
                            default: st <= P_SKIP;
                        endcase
                    end
                    P_RD_PIN: begin
                        if (is_readable(rx_byte)) begin
                            info.kind    <= RK_READ;
                            info.pin     <= rx_byte;
                            info.new_lvl <= pin_level(rx_byte, pins, tdo_i, test_in_i);
                            st           <= P_RD_END;
                        end else st <= bad_next(rx_byte);
                    end
                    P_WR_PIN: begin
                        if (is_writable(rx_byte)) begin
                            info.pin <= rx_byte;
                            st       <= P_WR_LVL;
                        end else st <= bad_next(rx_byte);
                    end
                    P_WR_LVL: begin
                        if (is_level(rx_byte)) begin
                            info.kind    <= RK_WRITE;
                            info.old_lvl <= pin_level(info.pin, pins, tdo_i, test_in_i);
                            info.new_lvl <= rx_byte[0];
                            case (info.pin)
                                "m":     pins.tms   <= rx_byte[0];
                                "c":     pins.tck   <= rx_byte[0];
                                "i":     pins.tdi   <= rx_byte[0];
                                "r":     pins.rst_n <= rx_byte[0];
                                default: pins.tout  <= rx_byte[0];
                            endcase
                            st <= P_WR_END;
                        end else st <= bad_next(rx_byte);
                    end
                    P_RD_END, P_WR_END: st <= (rx_byte == CH_LF) ? P_IDLE : P_SKIP;
                    P_JTAG: begin
                        case (rx_byte)
                            "m":     st <= P_J_TMS;
                            "i":     st <= P_J_TDI;
                            "^":     pins.tck <= 1'b1;
                            CH_LF: begin
                                info.kind <= RK_JTAG;
                                st        <= P_IDLE;
                            end
                            default: st <= P_SKIP;
                        endcase
                    end
                    P_J_TMS: begin
                        if (is_level(rx_byte)) begin
                            pins.tms <= rx_byte[0];
                            st       <= P_JTAG;
                        end else st <= bad_next(rx_byte);
                    end
                    P_J_TDI: begin
                        if (is_level(rx_byte)) begin
                            pins.tdi <= rx_byte[0];
                            st       <= P_JTAG;
                        end else st <= bad_next(rx_byte);
                    end
                    default: if (rx_byte == CH_LF) st <= P_IDLE;
                endcase
            end
        end
    end

    AST_CAP_BOUND: assert property (@(posedge clk) disable iff (rst)
        cap_cnt <= CAP_LIM); // R8
    AST_NO_PULSE_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(fall_stb && rx_fire)); // R12

endmodule

// File: rtl/scan_cmd_engine.sv
module scan_cmd_engine
    import scan_cmd_pkg::*;
#(
    parameter int HALF_CYC  = 4,
    parameter int CAP_DEPTH = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] rx_data,
    input  logic       rx_valid,
    output logic       rx_ready,
    output logic [7:0] tx_data,
    output logic       tx_valid,
    input  logic       tx_ready,
    output logic       tx_enable,
    output logic       tck_o,
    output logic       tms_o,
    output logic       tdi_o,
    output logic       tgt_rst_n_o,
    output logic       test_out_o,
    input  logic       tdo_i,
    input  logic       test_in_i
);
    localparam int CNT_W = $clog2(CAP_DEPTH + 1);
    localparam int IDX_W = $clog2(CAP_DEPTH + 8);

    logic                 pulse_busy, fall_stb, pulse_start;
    logic                 reply_busy, reply_start;
    reply_info_t          info;
    logic [CAP_DEPTH-1:0] cap_bits;
    logic [CNT_W-1:0]     cap_cnt;
    pin_state_t           pins;
    logic                 rx_fire;

    assign rx_ready = !pulse_busy && !reply_busy;
    assign rx_fire  = rx_valid && rx_ready;

    scan_cmd_parser #(.CAP_DEPTH(CAP_DEPTH), .CNT_W(CNT_W)) u_parser (
        .clk(clk), .rst(rst), .rx_fire(rx_fire), .rx_byte(rx_data),
        .fall_stb(fall_stb), .tdo_i(tdo_i), .test_in_i(test_in_i),
        .pulse_start(pulse_start), .reply_start(reply_start), .info(info),
        .cap_bits(cap_bits), .cap_cnt(cap_cnt), .pins(pins)
    );

    scan_cmd_pulse #(.HALF_CYC(HALF_CYC)) u_pulse (
        .clk(clk), .rst(rst), .start(pulse_start),
        .busy(pulse_busy), .fall_stb(fall_stb)
    );

    scan_cmd_reply #(.CAP_DEPTH(CAP_DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_reply (
        .clk(clk), .rst(rst), .start(reply_start), .info(info),
        .bits(cap_bits), .cnt(cap_cnt), .tx_ready(tx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .busy(reply_busy)
    );

    assign tx_enable   = reply_busy;
    assign tck_o       = pins.tck;
    assign tms_o       = pins.tms;
    assign tdi_o       = pins.tdi;
    assign tgt_rst_n_o = pins.rst_n;
    assign test_out_o  = pins.tout;

    AST_REPLY_ON_LF: assert property (@(posedge clk) disable iff (rst)
        $rose(reply_busy) |-> $past(rx_valid && rx_ready && rx_data == CH_LF)); // R13
    AST_TCK_LOW_AFTER_PULSE: assert property (@(posedge clk) disable iff (rst)
        $fell(pulse_busy) |-> !tck_o); // R6
    AST_ONE_ACTIVITY: assert property (@(posedge clk) disable iff (rst)
        !(pulse_busy && reply_busy)); // R12

endmodule

// File: tb/scan_cmd_engine_bench.sv
`timescale 1ns/1ps
module scan_cmd_engine_bench;
    localparam int HALF = 4;
    localparam int NV   = 16;

    localparam logic [127:0] V_CMD [NV] = '{
        "ra\n", "rm\n", "wa1\n", "ra\n", "wq1\n", "rx\n", "# hi ra\n", "ri\r\n",
        "jm0i1^i0^^\n", "rm\n", "j\n", "wr0\n", "rr\n", "rq\n", "ro\n", "zz\n"};
    localparam logic [127:0] V_EXP [NV] = '{
        "m> a:0\n", "m> m:1\n", "m> a:0->1\n", "m> a:1\n", "", "", "", "m> i:1\n",
        "m> 100 ok\n", "m> m:0\n", "m>  ok\n", "m> r:1->0\n", "m> r:0\n",
        "m> q:1\n", "m> o:0\n", ""};
    localparam logic [23:0] V_TAG [NV] = '{
        "R2 ", "R2 ", "R3 ", "R3 ", "R4 ", "R4 ", "R9 ", "R10",
        "R7 ", "R5 ", "R7 ", "R3 ", "R2 ", "R2 ", "R2 ", "R4 "};

    logic       clk = 1'b0, rst = 1'b1;
    logic [7:0] rx_data = 8'h00;
    logic       rx_valid = 1'b0, tx_ready = 1'b1, test_in_i = 1'b1;
    logic       rx_ready, tx_valid, tx_enable, tck_o, tms_o, tdi_o, tgt_rst_n_o, test_out_o;
    logic [7:0] tx_data;
    logic       tdo_i;

    int n_chk = 0, n_bad = 0;
    int col_len = 0, pulses = 0;
    logic [7:0] col_mem [0:255];
    logic [7:0] exp_buf [0:63];
    int exp_n;
    logic tck_prev = 1'b0;
    bit done = 0;

    always #2.5 clk = ~clk;
    assign tdo_i = tdi_o;

    scan_cmd_engine #(.HALF_CYC(HALF), .CAP_DEPTH(32)) u_scan_cmd_engine (
        .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_enable(tx_enable),
        .tck_o(tck_o), .tms_o(tms_o), .tdi_o(tdi_o), .tgt_rst_n_o(tgt_rst_n_o),
        .test_out_o(test_out_o), .tdo_i(tdo_i), .test_in_i(test_in_i));

    always @(negedge clk) begin
        if (!rst && tx_valid && tx_ready) begin
            if (col_len < 256) col_mem[col_len] = tx_data;
            col_len = col_len + 1;
        end
        if (tck_o && !tck_prev) pulses = pulses + 1;
        tck_prev = tck_o;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(posedge clk); #1;
        rx_valid = 1'b1; rx_data = b;
        do @(negedge clk); while (!rx_ready);
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic send_str(input logic [127:0] s);
        for (int i = 15; i >= 0; i--)
            if (s[i*8 +: 8] != 8'h00) send_byte(s[i*8 +: 8]);
    endtask

    task automatic load_exp(input logic [127:0] s);
        exp_n = 0;
        for (int i = 15; i >= 0; i--)
            if (s[i*8 +: 8] != 8'h00) begin exp_buf[exp_n] = s[i*8 +: 8]; exp_n++; end
    endtask

    task automatic quiet();
        repeat (70) @(negedge clk);
    endtask

    task automatic check_reply(input int base, input string req);
        int got = col_len - base;
        bit ok = (got == exp_n);
        int bad_at = -1;
        if (ok)
            for (int k = 0; k < exp_n; k++)
                if (col_mem[base + k] != exp_buf[k] && bad_at < 0) begin ok = 0; bad_at = k; end
        if (!ok && got != exp_n) check(0, {req, " reply length"}, got, exp_n);
        else if (!ok) check(0, {req, " reply char"}, int'(col_mem[base + bad_at]), int'(exp_buf[bad_at]));
        else check(1, req, got, exp_n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int base, p0, hi, lo;
        repeat (3) @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!tck_o && tms_o && tdi_o && tgt_rst_n_o && !test_out_o && !tx_valid && !tx_enable,
              "R1", {tck_o, tms_o, tdi_o, tgt_rst_n_o, test_out_o}, 5'b01110);

        for (int v = 0; v < NV; v++) begin
            base = col_len;
            load_exp(V_EXP[v]);
            send_str(V_CMD[v]);
            quiet();
            check_reply(base, string'(V_TAG[v]));
        end

        // R13 / R3: pin changes before LF, reply only after it
        base = col_len;
        send_byte("w"); send_byte("m"); send_byte("1");
        @(negedge clk);
        check(tms_o == 1'b1, "R3 tms before LF", tms_o, 1);
        repeat (10) @(negedge clk);
        check(col_len == base, "R13 no early reply", col_len - base, 0);
        send_byte(8'h0A); quiet();
        load_exp("m> m:0->1\n"); check_reply(base, "R13");

        // R6: pulse timing and TDO capture at fall
        base = col_len;
        send_byte("j"); send_byte("^");
        @(negedge clk);
        hi = 0; while (tck_o && hi < 100) begin hi++; @(negedge clk); end
        lo = 0; while (!rx_ready && lo < 100) begin lo++; @(negedge clk); end
        check(hi == HALF, "R6 high clocks", hi, HALF);
        check(lo == HALF, "R6 low clocks", lo, HALF);
        send_byte(8'h0A); quiet();
        load_exp("m> 0 ok\n"); check_reply(base, "R6");

        // R8: capture limit
        base = col_len; p0 = pulses;
        send_byte("j"); send_byte("i"); send_byte("1");
        for (int k = 0; k < 34; k++) send_byte("^");
        send_byte(8'h0A); quiet();
        check(pulses - p0 == 34, "R8 pulses", pulses - p0, 34);
        exp_n = 0;
        exp_buf[0] = "m"; exp_buf[1] = ">"; exp_buf[2] = " ";
        for (int k = 0; k < 32; k++) exp_buf[3 + k] = "1";
        exp_buf[35] = " "; exp_buf[36] = "o"; exp_buf[37] = "k"; exp_buf[38] = 8'h0A;
        exp_n = 39;
        check_reply(base, "R8");

        // R11 / R12: stalled reply holds
        @(posedge clk); #1 tx_ready = 1'b0;
        base = col_len;
        send_str("ra\n");
        repeat (4) @(negedge clk);
        check(tx_valid && tx_enable && tx_data == "m", "R11 hold", int'(tx_data), int'("m"));
        check(!rx_ready, "R12 rx held off", rx_ready, 0);
        @(posedge clk); #1 tx_ready = 1'b1;
        quiet();
        load_exp("m> a:1\n"); check_reply(base, "R11");
        check(!tx_enable, "R11 enable drops", tx_enable, 0);

        // R4: bad level inside scan drops line, no pulse, no tms change
        base = col_len; p0 = pulses;
        send_str("jm2^\n"); quiet();
        check(pulses == p0 && tms_o == 1'b1, "R4 scan abort", pulses - p0, 0);
        load_exp(""); check_reply(base, "R4");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule